// File: doc/BRIEF.md
# 8-bit ALU with Program Status Word

This block is the arithmetic and flag core of a small 8-bit controller. On each accepted operation it combines two operands and an incoming carry, captures the result in an output register and folds new values into an 8-bit status word. The status word holds eight flags, named here from bit 7 down to bit 0:

- `N`: sign
- `V`: signed overflow
- `G`: direct-page select
- `B`: break
- `H`: half carry
- `I`: interrupt enable
- `Z`: zero
- `C`: carry

Each class of operation writes only its own subset of these flags. The block also carries out the single-purpose flag operations: select or deselect the upper direct page, enable or disable interrupts, and clear overflow. A separate load port restores the whole word at once, as needed when returning from an interrupt or popping status from the stack. The `G` flag is brought out as the high bit of the direct-page address. When it is 0 the direct window is 0x000–0x0FF; when it is 1 the window is 0x100–0x1FF.

Operations enter as a stream with a valid qualifier and no ready signal. The block accepts one operation per clock and never applies back-pressure, so an upstream stage may present `op_valid` on any cycle. The registered result comes out one cycle later with `res_valid`, and the consumer must take it in that cycle. On cycles with no operation, `res_valid` is low and `result` holds its last value.

Top module: `alu8_psw`

## Requirements
- R1: After reset (`rst_n` low), `psw` is 0x00, `result` is 0x00, `res_valid` is 0 and `dp_hi` is 0.
- R2: A high `psw_load` writes all eight bits of `psw_load_data` into `psw` at the next edge. This takes priority over any flag update from an operation accepted in the same cycle. The status bits are ordered from bit 7 to bit 0 as N, V, G, B, H, I, Z, C.
- R3: Add with carry (code 0) computes result = a + b + carry_in modulo 256.
  - C is the carry out of bit 7.
  - H is the carry out of bit 3.
  - V is 1 when the signed sum falls outside −128..+127.
  - N is bit 7 of the result, and Z is 1 when the result is zero.
  - G, B and I are unchanged.
- R4: Subtract with carry (code 1) computes result = a − b − (1 − carry_in) modulo 256.
  - C is 1 when no borrow occurs.
  - H is 1 when there is no borrow from bit 4.
  - V is 1 when the signed difference falls outside −128..+127.
  - N and Z follow the result.
  - G, B and I are unchanged.
- R5: AND (code 2), OR (code 3) and XOR (code 4) of a and b update only N and Z. C, V, H and all other flags stay unchanged.
- R6: The shift and rotate operations act on a and set C from the bit shifted out. N and Z follow the result.
  - Shift left (code 5) shifts a 0 into bit 0 and moves a[7] into C.
  - Logical shift right (code 6) shifts a 0 into bit 7 and moves a[0] into C.
  - Rotate left (code 7) brings carry_in into bit 0 and moves a[7] into C.
  - Rotate right (code 8) brings carry_in into bit 7 and moves a[0] into C.
- R7: Transfer (code 10) passes b to the result and updates only N and Z.
- R8: Bit test (code 9) returns a unchanged as the result.
  - N takes b[7] and V takes b[6].
  - Z is 1 when (a AND b) is zero.
  - All other flags stay unchanged.
- R9: Code 11 sets G and code 12 clears G. `dp_hi` always equals `psw` bit 5.
- R10: Code 13 sets I and code 14 clears I. No other flag changes.
- R11: Code 15 clears both V and H and leaves the other six flags unchanged. No operation sets V on its own.
- R12: `res_valid` is high in exactly the cycle after a cycle with `op_valid` high. In a cycle with neither `op_valid` nor `psw_load`, `psw` is unchanged.
- R13: B changes only through `psw_load`. No operation code writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation select, codes 0–15 |
| opnd_a | input | 8 | First operand (shift source, bit-test accumulator) |
| opnd_b | input | 8 | Second operand (bit-test memory byte) |
| carry_in | input | 1 | Carry into add, subtract and rotate |
| psw_load | input | 1 | Restore the whole status word |
| psw_load_data | input | 8 | Status word to restore |
| result | output | 8 | Registered operation result |
| res_valid | output | 1 | Result register updated last edge |
| psw | output | 8 | Program status word |
| dp_hi | output | 1 | Direct-page high address bit (copy of G) |

## Verification
The assertions assume that `op_code` is always a defined 4-bit value whenever `op_valid` is high. They also assume that `psw_load` is never left unknown, because the priority rule between a load and an operation depends on it. The stimulus respects both assumptions: it draws every code from the full 0–15 range and drives the load and valid controls from explicit random bits. Starting status words for the flag operations come from random loads, so that setting or clearing one flag happens against every mix of the other seven. Fixed cases pin down the half-carry and overflow boundaries, the no-borrow convention of subtraction, and a load that collides with an operation in the same cycle.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADC  = 4'd0,
    OP_SBC  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_ASL  = 4'd5,
    OP_LSR  = 4'd6,
    OP_ROL  = 4'd7,
    OP_ROR  = 4'd8,
    OP_BIT  = 4'd9,
    OP_PASS = 4'd10,
    OP_SETG = 4'd11,
    OP_CLRG = 4'd12,
    OP_EI   = 4'd13,
    OP_DI   = 4'd14,
    OP_CLRV = 4'd15
  } alu_op_e;

  localparam int unsigned PSW_W = 8;
  localparam int unsigned FL_N  = 7;
  localparam int unsigned FL_V  = 6;
  localparam int unsigned FL_G  = 5;
  localparam int unsigned FL_B  = 4;
  localparam int unsigned FL_H  = 3;
  localparam int unsigned FL_I  = 2;
  localparam int unsigned FL_Z  = 1;
  localparam int unsigned FL_C  = 0;

  typedef struct packed {
    logic [PSW_W-1:0] val;
    logic [PSW_W-1:0] wr;
  } flag_upd_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] res,
  output flag_upd_t     upd
);
  localparam int unsigned HALF = DW / 2;

  logic [DW-1:0]   b_eff;
  logic [DW:0]     full_sum;
  logic [HALF:0]   low_sum;

  always_comb begin
    b_eff    = sub ? ~b : b;
    full_sum = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
    low_sum  = {1'b0, a[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, cin};
    res      = full_sum[DW-1:0];

    upd            = '0;
    upd.val[FL_N]  = res[DW-1];
    upd.val[FL_V]  = (a[DW-1] == b_eff[DW-1]) && (res[DW-1] != a[DW-1]);
    upd.val[FL_H]  = low_sum[HALF];
    upd.val[FL_Z]  = (res == '0);
    upd.val[FL_C]  = full_sum[DW];
    upd.wr[FL_N]   = 1'b1;
    upd.wr[FL_V]   = 1'b1;
    upd.wr[FL_H]   = 1'b1;
    upd.wr[FL_Z]   = 1'b1;
    upd.wr[FL_C]   = 1'b1;
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] res,
  output flag_upd_t     upd
);
  localparam int unsigned MSB = DW - 1;

  always_comb begin
    res = a;
    upd = '0;
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_PASS: res = b;
      OP_ASL: begin res = {a[MSB-1:0], 1'b0}; upd.val[FL_C] = a[MSB]; end
      OP_LSR: begin res = {1'b0, a[MSB:1]};   upd.val[FL_C] = a[0];   end
      OP_ROL: begin res = {a[MSB-1:0], cin};  upd.val[FL_C] = a[MSB]; end
      OP_ROR: begin res = {cin, a[MSB:1]};    upd.val[FL_C] = a[0];   end
      default: res = a;
    endcase

    unique case (op)
      OP_AND, OP_OR, OP_XOR, OP_PASS: begin
        upd.val[FL_N] = res[MSB];
        upd.val[FL_Z] = (res == '0);
        upd.wr[FL_N]  = 1'b1;
        upd.wr[FL_Z]  = 1'b1;
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        upd.val[FL_N] = res[MSB];
        upd.val[FL_Z] = (res == '0);
        upd.wr[FL_N]  = 1'b1;
        upd.wr[FL_Z]  = 1'b1;
        upd.wr[FL_C]  = 1'b1;
      end
      OP_BIT: begin
        upd.val[FL_N] = b[MSB];
        upd.val[FL_V] = b[MSB-1];
        upd.val[FL_Z] = ((a & b) == '0);
        upd.wr[FL_N]  = 1'b1;
        upd.wr[FL_V]  = 1'b1;
        upd.wr[FL_Z]  = 1'b1;
      end
      default: upd.wr = '0;
    endcase
  end

endmodule

// File: rtl/alu8_psw_reg.sv
module alu8_psw_reg
  import alu8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [PSW_W-1:0] ld_data,
  input  logic             upd_en,
  input  flag_upd_t        upd,
  output logic [PSW_W-1:0] psw
);

  always_ff @(posedge clk) begin
    if (!rst_n)      psw <= '0;
    else if (ld)     psw <= ld_data;
    else if (upd_en) psw <= (psw & ~upd.wr) | (upd.val & upd.wr);
  end

  AST_LOAD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> psw == $past(ld_data)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !upd_en) |=> $stable(psw)); // R12
  AST_B_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> psw[FL_B] == $past(psw[FL_B])); // R13

endmodule

// File: rtl/alu8_psw.sv
module alu8_psw
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [3:0]       op_code,
  input  logic [DW-1:0]    opnd_a,
  input  logic [DW-1:0]    opnd_b,
  input  logic             carry_in,
  input  logic             psw_load,
  input  logic [PSW_W-1:0] psw_load_data,
  output logic [DW-1:0]    result,
  output logic             res_valid,
  output logic [PSW_W-1:0] psw,
  output logic             dp_hi
);
  alu_op_e     op;
  logic        is_arith;
  logic [DW-1:0] arith_res, logic_res, next_res;
  flag_upd_t   arith_upd, logic_upd, ctrl_upd, sel_upd;

  assign op       = alu_op_e'(op_code);
  assign is_arith = (op == OP_ADC) || (op == OP_SBC);

  alu8_addsub #(.DW(DW)) u_addsub (
    .a(opnd_a), .b(opnd_b), .cin(carry_in), .sub(op == OP_SBC),
    .res(arith_res), .upd(arith_upd)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .op(op), .a(opnd_a), .b(opnd_b), .cin(carry_in),
    .res(logic_res), .upd(logic_upd)
  );

  always_comb begin
    ctrl_upd = '0;
    unique case (op)
      OP_SETG: begin ctrl_upd.wr[FL_G] = 1'b1; ctrl_upd.val[FL_G] = 1'b1; end
      OP_CLRG: ctrl_upd.wr[FL_G] = 1'b1;
      OP_EI:   begin ctrl_upd.wr[FL_I] = 1'b1; ctrl_upd.val[FL_I] = 1'b1; end
      OP_DI:   ctrl_upd.wr[FL_I] = 1'b1;
      OP_CLRV: begin ctrl_upd.wr[FL_V] = 1'b1; ctrl_upd.wr[FL_H] = 1'b1; end
      default: ctrl_upd = '0;
    endcase
    sel_upd  = is_arith ? arith_upd : (logic_upd | ctrl_upd);
    next_res = is_arith ? arith_res : logic_res;
  end

  alu8_psw_reg u_psw (
    .clk(clk), .rst_n(rst_n), .ld(psw_load), .ld_data(psw_load_data),
    .upd_en(op_valid), .upd(sel_upd), .psw(psw)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) result <= next_res;
    end
  end

  assign dp_hi = psw[FL_G];

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid); // R12
  AST_LOGIC_KEEPS_CVH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !psw_load && (op == OP_AND || op == OP_OR || op == OP_XOR))
      |=> (psw[FL_C] == $past(psw[FL_C])) && (psw[FL_V] == $past(psw[FL_V]))
          && (psw[FL_H] == $past(psw[FL_H]))); // R5
  AST_CLRV_CLEARS_VH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !psw_load && op == OP_CLRV) |=> !psw[FL_V] && !psw[FL_H]); // R11
  AST_SETG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !psw_load && op == OP_SETG) |=> dp_hi); // R9
  AST_EI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !psw_load && op == OP_EI) |=> psw[FL_I]); // R10
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !psw_load && (is_arith || op == OP_PASS || op == OP_XOR))
      |=> psw[FL_Z] == (result == '0)); // R3

endmodule

// File: tb/alu8_psw_tb.sv
module alu8_psw_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [3:0] op_code;
  logic [7:0] opnd_a, opnd_b;
  logic       carry_in;
  logic       psw_load;
  logic [7:0] psw_load_data;
  logic [7:0] result;
  logic       res_valid;
  logic [7:0] psw;
  logic       dp_hi;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [7:0] exp_psw;
  logic [7:0] exp_res;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_psw u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
    .psw_load(psw_load), .psw_load_data(psw_load_data),
    .result(result), .res_valid(res_valid), .psw(psw), .dp_hi(dp_hi)
  );

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2, 4'd3, 4'd4: return "R5";
      4'd5, 4'd6, 4'd7, 4'd8: return "R6";
      4'd9: return "R8";
      4'd10: return "R7";
      4'd11, 4'd12: return "R9";
      4'd13, 4'd14: return "R10";
      default: return "R11";
    endcase
  endfunction

  // returns {result, flags}
  function automatic logic [15:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic ci,
                                        input logic [7:0] p);
    logic [7:0] r; logic [7:0] q; int s, lo;
    r = a; q = p;
    case (op)
      4'd0: begin
        s = int'(a) + int'(b) + int'(ci);
        lo = int'(a & 8'h0F) + int'(b & 8'h0F) + int'(ci);
        r = s[7:0]; q[0] = (s > 255); q[3] = (lo > 15);
        s = int'($signed(a)) + int'($signed(b)) + int'(ci);
        q[6] = (s > 127) || (s < -128);
      end
      4'd1: begin
        s = int'(a) - int'(b) - int'(!ci);
        lo = int'(a & 8'h0F) - int'(b & 8'h0F) - int'(!ci);
        r = s[7:0]; q[0] = (s >= 0); q[3] = (lo >= 0);
        s = int'($signed(a)) - int'($signed(b)) - int'(!ci);
        q[6] = (s > 127) || (s < -128);
      end
      4'd2: r = a & b;
      4'd3: r = a | b;
      4'd4: r = a ^ b;
      4'd5: begin r = a << 1; q[0] = a[7]; end
      4'd6: begin r = a >> 1; q[0] = a[0]; end
      4'd7: begin r = (a << 1) | {7'd0, ci}; q[0] = a[7]; end
      4'd8: begin r = (a >> 1) | {ci, 7'd0}; q[0] = a[0]; end
      4'd9: begin r = a; q[7] = b[7]; q[6] = b[6]; q[1] = ((a & b) == 0); end
      4'd10: r = b;
      4'd11: q[5] = 1'b1;
      4'd12: q[5] = 1'b0;
      4'd13: q[2] = 1'b1;
      4'd14: q[2] = 1'b0;
      default: begin q[6] = 1'b0; q[3] = 1'b0; end
    endcase
    if (op <= 4'd8 || op == 4'd10) begin q[7] = r[7]; q[1] = (r == 0); end
    return {r, q};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // apply one cycle of stimulus and check the outcome after the edge
  task automatic step(input logic v, input logic [3:0] op, input logic [7:0] a,
                      input logic [7:0] b, input logic ci, input logic ld,
                      input logic [7:0] ldd);
    logic [15:0] m;
    op_valid = v; op_code = op; opnd_a = a; opnd_b = b; carry_in = ci;
    psw_load = ld; psw_load_data = ldd;
    m = model(op, a, b, ci, exp_psw);
    if (v) exp_res = m[15:8];
    if (ld) exp_psw = ldd;
    else if (v) exp_psw = m[7:0];
    @(posedge clk); #1;
    if (ld) check("R2", {24'd0, psw}, {24'd0, exp_psw});
    else if (v) check(tag_of(op), {16'd0, result, psw}, {16'd0, exp_res, exp_psw});
    else check("R12", {23'd0, res_valid, psw}, {23'd0, 1'b0, exp_psw});
    if (v) check("R12", {31'd0, res_valid}, 32'd1);
    check("R9", {31'd0, dp_hi}, {31'd0, exp_psw[5]});
    op_valid = 0; psw_load = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; op_valid = 0; op_code = 0; opnd_a = 0; opnd_b = 0;
    carry_in = 0; psw_load = 0; psw_load_data = 0;
    exp_psw = 8'h00; exp_res = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {15'd0, result, res_valid, psw}, 32'd0);
    check("R1", {31'd0, dp_hi}, 32'd0);
    rst_n = 1;

    // R3 directed: signed overflow, half carry, carry out
    step(1, 4'd0, 8'h7F, 8'h01, 0, 0, 0);
    step(1, 4'd0, 8'h0F, 8'h00, 1, 0, 0);
    step(1, 4'd0, 8'hFF, 8'h01, 0, 0, 0);
    // R4 directed: no borrow gives C=1; borrow from bit 4 clears H
    step(1, 4'd1, 8'h10, 8'h01, 1, 0, 0);
    step(1, 4'd1, 8'h80, 8'h01, 1, 0, 0);
    step(1, 4'd1, 8'h00, 8'h00, 0, 0, 0);
    // R11 clear overflow after it is set
    step(1, 4'd0, 8'h7F, 8'h7F, 1, 0, 0);
    step(1, 4'd15, 8'h00, 8'h00, 0, 0, 0);
    // R8 bit test
    step(1, 4'd9, 8'h3C, 8'hC0, 0, 0, 0);
    // R13 B set only by load; ops keep it
    step(0, 4'd0, 0, 0, 0, 1, 8'h10);
    step(1, 4'd15, 8'h00, 8'h00, 0, 0, 0);
    check("R13", {31'd0, psw[4]}, 32'd1);
    // R2 load collides with operation
    step(1, 4'd11, 8'h00, 8'h00, 0, 1, 8'hA5);
    // R9 / R10 directed
    step(1, 4'd12, 0, 0, 0, 0, 0);
    step(1, 4'd11, 0, 0, 0, 0, 0);
    step(1, 4'd14, 0, 0, 0, 0, 0);
    step(1, 4'd13, 0, 0, 0, 0, 0);
    // R6 rotates with carry in
    step(1, 4'd7, 8'h80, 0, 1, 0, 0);
    step(1, 4'd8, 8'h01, 0, 1, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] sel;
      sel = 4'($urandom % 16);
      if (sel == 4'd0)
        step(0, 4'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 1, 8'($urandom));
      else if (sel == 4'd1)
        step(0, 4'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 0, 0);
      else
        step(1, 4'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
             ($urandom % 32) == 0, 8'($urandom));
    end
    finish_run();
  end

endmodule